// File: doc/BRIEF.md
# Nested Abort Preemption Handler

This unit sits beside a processor's control unit and decides when a guarded code region must be left. Each time the control unit executes an abort instruction, it pushes a context onto a small stack. The context names one line of an external input vector to watch and the address at which execution continues once that line fires. When the guarded body finishes normally, the control unit pops the context.

The unit watches every live context in parallel, every cycle, so the program never polls. If one or more watched lines are high, the context closest to the bottom of the stack wins, because that is the outermost abort. The unit then issues a one-cycle preempt strobe to the program counter together with the winner's continuation address. In the same edge it cuts the stack back so that the winner and every context nested inside it are gone. The strobe is registered and appears on the first clock edge after the cycle in which the line was sampled high, which bounds the response to one cycle.

Top module: `abort_preempt_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, the stack depth reads 0, the preempt strobe is low and the overflow flag is clear.
- R2: A push with free space stores the watched index and continuation address at stack position `depth` and raises depth by one. A pop with a non-empty stack lowers depth by one. A pop on an empty stack leaves depth at 0.
- R3: A push (without pop) at full depth is ignored: depth stays at `DEPTH`. It sets the overflow flag, which stays set until reset.
- R4: When a live context's watched bit of `watch_i` (bit number = stored index) is high in a cycle, the strobe and that context's address appear on the next clock edge. The strobe lasts exactly one cycle unless a fresh fire follows.
- R5: If several live contexts fire together, the one at the lowest stack position wins. Position 0 is the first pushed and therefore the outermost.
- R6: After a preemption, depth equals the winner's stack position, so the winner and all inner contexts are removed.
- R7: A watched bit that is high in the cycle the context is pushed does not fire it. Evaluation starts in the following cycle.
- R8: A fire takes precedence over a pop or a push in the same cycle. Both are dropped.
- R9: A push and a pop in the same cycle replace the top context and leave depth unchanged. On an empty stack the pair acts as a push.
- R10: Contexts at positions at or above the current depth, whether popped or preempted, never fire, whatever their stale index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Open a guarded region (push a context) |
| push_sig_i | input | $clog2(SIG_W) | Bit number of `watch_i` to watch |
| push_addr_i | input | ADDR_W | Continuation address for the new context |
| pop_i | input | 1 | Guarded region ended normally (pop the top context) |
| watch_i | input | SIG_W | External input vector being monitored |
| preempt_o | output | 1 | One-cycle jump request to the program counter |
| preempt_addr_o | output | ADDR_W | Continuation address of the winning context |
| depth_o | output | $clog2(DEPTH+1) | Number of live contexts |
| overflow_o | output | 1 | Sticky flag: a push was attempted at full depth |

## Verification
The bench fires an inner and a middle context together. A resolver that favoured the innermost context would jump to the wrong address and leave the wrong depth. It also checks that depth falls to the winner's position and not just by one, which is where a design that pops a single entry on fire would diverge. A pop or a push is issued in the same cycle as a fire, and a design that honoured either would end one level off. A line is held high through the push of the context that watches it, so a design that evaluated the new entry at once would fire a cycle early. Finally the stack is filled past its limit and then has its top swapped. A non-sticky flag or a push written past the top would show on the overflow output or on a later preemption address.

// File: rtl/abort_pkg.sv
package abort_pkg;
  // Stack operation chosen in a cycle without a fire.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stack_op_e;
endpackage

// File: rtl/abort_ctx_stack.sv
module abort_ctx_stack
  import abort_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push_i,
  input  logic [IDX_W-1:0]       push_sig_i,
  input  logic                   pop_i,
  input  logic                   fire_i,
  input  logic [PTR_W-1:0]       fire_pos_i,
  output logic [CNT_W-1:0]       depth_o,
  output logic [DEPTH-1:0]       live_o,
  output logic [DEPTH*IDX_W-1:0] sig_flat_o,
  output logic                   overflow_o,
  output logic                   wr_en_o,
  output logic [PTR_W-1:0]       wr_pos_o
);
  stack_op_e        op;
  logic             full, empty;
  logic [CNT_W-1:0] depth_q;
  logic             ovf_q;

  assign full  = (depth_q == CNT_W'(DEPTH));
  assign empty = (depth_q == '0);

  always_comb begin
    op = OP_NONE;
    if (!fire_i) begin
      if (push_i && pop_i && !empty)  op = OP_SWAP;
      else if (push_i && !full)       op = OP_PUSH;
      else if (pop_i && !push_i && !empty) op = OP_POP;
    end
  end

  assign wr_en_o  = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_pos_o = (op == OP_SWAP) ? PTR_W'(depth_q - 1'b1) : PTR_W'(depth_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (fire_i) depth_q <= CNT_W'(fire_pos_i);
      else if (op == OP_PUSH) depth_q <= depth_q + 1'b1;
      else if (op == OP_POP)  depth_q <= depth_q - 1'b1;
      if (!fire_i && push_i && !pop_i && full) ovf_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [IDX_W-1:0] sig_q;
    always_ff @(posedge clk) begin
      if (rst) sig_q <= '0;
      else if (wr_en_o && wr_pos_o == PTR_W'(g)) sig_q <= push_sig_i;
    end
    assign sig_flat_o[g*IDX_W +: IDX_W] = sig_q;
    assign live_o[g] = (depth_q > CNT_W'(g));
  end

  assign depth_o    = depth_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/abort_hit_resolve.sv
module abort_hit_resolve #(
  parameter int DEPTH = 8,
  parameter int SIG_W = 32,
  localparam int IDX_W = $clog2(SIG_W),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]       live_i,
  input  logic [DEPTH*IDX_W-1:0] sig_flat_i,
  input  logic [SIG_W-1:0]       watch_i,
  output logic                   fire_o,
  output logic [PTR_W-1:0]       win_pos_o
);
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = live_i[g] & watch_i[sig_flat_i[g*IDX_W +: IDX_W]];
  end

  // Lowest position (outermost abort) wins.
  always_comb begin
    win_pos_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) win_pos_o = PTR_W'(i);
    end
  end

  assign fire_o = |hit;
endmodule

// File: rtl/abort_cont_ram.sv
module abort_cont_ram #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wpos_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  rpos_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wpos_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[rpos_i];
  end
endmodule

// File: rtl/abort_preempt_unit.sv
module abort_preempt_unit #(
  parameter int DEPTH  = 8,
  parameter int SIG_W  = 32,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(SIG_W),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_sig_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  input  logic [SIG_W-1:0]  watch_i,
  output logic              preempt_o,
  output logic [ADDR_W-1:0] preempt_addr_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              overflow_o
);
  logic                   fire;
  logic [PTR_W-1:0]       win_pos;
  logic [DEPTH-1:0]       live;
  logic [DEPTH*IDX_W-1:0] sig_flat;
  logic                   wr_en;
  logic [PTR_W-1:0]       wr_pos;

  abort_ctx_stack #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_stack (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push_i),
    .push_sig_i (push_sig_i),
    .pop_i      (pop_i),
    .fire_i     (fire),
    .fire_pos_i (win_pos),
    .depth_o    (depth_o),
    .live_o     (live),
    .sig_flat_o (sig_flat),
    .overflow_o (overflow_o),
    .wr_en_o    (wr_en),
    .wr_pos_o   (wr_pos)
  );

  abort_hit_resolve #(.DEPTH(DEPTH), .SIG_W(SIG_W)) u_resolve (
    .live_i     (live),
    .sig_flat_i (sig_flat),
    .watch_i    (watch_i),
    .fire_o     (fire),
    .win_pos_o  (win_pos)
  );

  abort_cont_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en),
    .wpos_i  (wr_pos),
    .wdata_i (push_addr_i),
    .re_i    (fire),
    .rpos_i  (win_pos),
    .rdata_o (preempt_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) preempt_o <= 1'b0;
    else     preempt_o <= fire;
  end
endmodule

// File: rtl/abort_preempt_checker.sv
module abort_preempt_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             preempt_o,
  input logic [CNT_W-1:0] depth_o,
  input logic             overflow_o
);
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(depth_o) <= DEPTH);

  assert_depth_step_R2: assert property (@(posedge clk) disable iff (rst)
    !preempt_o |-> (int'(depth_o) <= int'($past(depth_o)) + 1) &&
                   (int'(depth_o) + 1 >= int'($past(depth_o))));

  assert_truncate_R6: assert property (@(posedge clk) disable iff (rst)
    preempt_o |-> int'(depth_o) < int'($past(depth_o)));

  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  assert_ovf_at_full_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow_o) |-> int'($past(depth_o)) == DEPTH);
endmodule

bind abort_preempt_unit abort_preempt_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .preempt_o  (preempt_o),
  .depth_o    (depth_o),
  .overflow_o (overflow_o)
);

// File: tb/abort_preempt_unit_test.sv
module abort_preempt_unit_test;
  localparam int DEPTH = 8, SIG_W = 32, ADDR_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic push_i = 0, pop_i = 0;
  logic [4:0] push_sig_i = '0;
  logic [ADDR_W-1:0] push_addr_i = '0;
  logic [SIG_W-1:0] watch_i = '0;
  logic preempt_o, overflow_o;
  logic [ADDR_W-1:0] preempt_addr_o;
  logic [3:0] depth_o;

  always #4 clk = ~clk;  // 125 MHz

  abort_preempt_unit #(.DEPTH(DEPTH), .SIG_W(SIG_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .push_i(push_i), .push_sig_i(push_sig_i),
    .push_addr_i(push_addr_i), .pop_i(pop_i), .watch_i(watch_i),
    .preempt_o(preempt_o), .preempt_addr_o(preempt_addr_o),
    .depth_o(depth_o), .overflow_o(overflow_o));

  typedef struct {
    int    when;
    bit    pre;
    int    addr;
    int    dep;
    bit    ovf;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, vectors = 0, miscompares = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares expectations scheduled for this cycle.
  initial forever begin
    @(posedge clk); #2;
    while (q.size() > 0 && q[0].when == cyc) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (preempt_o !== e.pre || int'(depth_o) != e.dep || overflow_o !== e.ovf ||
          (e.pre && int'(preempt_addr_o) != e.addr)) begin
        miscompares++;
        $display("FAIL %s: got pre=%0b addr=%h depth=%0d ovf=%0b, expected pre=%0b addr=%h depth=%0d ovf=%0b",
                 e.req, preempt_o, preempt_addr_o, depth_o, overflow_o,
                 e.pre, e.addr[15:0], e.dep, e.ovf);
      end
    end
  end

  // Driver: applies one cycle of inputs and queues the result for the next cycle.
  task automatic step(bit psh, int sidx, int paddr, bit pp, logic [31:0] w,
                      bit epre, int eaddr, int edep, bit eovf, string req);
    exp_t e;
    push_i = psh; push_sig_i = sidx[4:0]; push_addr_i = paddr[15:0];
    pop_i = pp; watch_i = w;
    e.when = cyc + 1; e.pre = epre; e.addr = eaddr; e.dep = edep; e.ovf = eovf; e.req = req;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic reset_cycle(string req);
    exp_t e;
    rst = 1; push_i = 0; pop_i = 0; watch_i = '0;
    e.when = cyc + 1; e.pre = 0; e.addr = 0; e.dep = 0; e.ovf = 0; e.req = req;
    q.push_back(e);
    @(posedge clk); #1;
    rst = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    reset_cycle("R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 pushes
    step(1, 3, 'h1000, 0, 0, 0, 0, 1, 0, "R2");
    step(1, 7, 'h2000, 0, 0, 0, 0, 2, 0, "R2");
    step(1, 9, 'h3000, 0, 0, 0, 0, 3, 0, "R2");
    // R5 + R6: middle and inner fire together, middle wins, depth -> 1
    step(0, 0, 0, 0, (32'd1 << 7) | (32'd1 << 9), 1, 'h2000, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
    // R7: watched bit high during push does not fire
    step(1, 12, 'h4000, 0, 32'd1 << 12, 0, 0, 2, 0, "R7");
    step(0, 0, 0, 0, 32'd1 << 12, 1, 'h4000, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    // R8: pop in fire cycle dropped
    step(1, 20, 'h5000, 0, 0, 0, 0, 2, 0, "R2");
    step(0, 0, 0, 1, 32'd1 << 20, 1, 'h5000, 1, 0, "R8");
    // R2 pop, pop on empty
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    // R10: stale index 3 no longer live
    step(0, 0, 0, 0, 32'd1 << 3, 0, 0, 0, 0, "R10");
    // R3: fill to full then overflow
    for (int i = 0; i < DEPTH; i++)
      step(1, 21 + i, 'h6000 + i, 0, 0, 0, 0, i + 1, 0, "R2");
    step(1, 31, 'hdead, 0, 0, 0, 0, 8, 1, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 8, 1, "R3");
    // R9: swap top at full
    step(1, 30, 'h7777, 1, 0, 0, 0, 8, 1, "R9");
    step(0, 0, 0, 0, 32'd1 << 30, 1, 'h7777, 7, 1, "R9");
    step(0, 0, 0, 0, (32'd1 << 21) | (32'd1 << 24), 1, 'h6000, 0, 1, "R5");
    // R9: push+pop on empty acts as push
    step(1, 5, 'h0abc, 1, 0, 0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 32'd1 << 5, 1, 'h0abc, 0, 1, "R4");
    // R8: push in fire cycle dropped
    step(1, 2, 'h1111, 0, 0, 0, 0, 1, 1, "R2");
    step(1, 4, 'h2222, 0, 32'd1 << 2, 1, 'h1111, 0, 1, "R8");
    step(0, 0, 0, 0, 32'd1 << 4, 0, 0, 0, 1, "R8");
    // R1: reset clears the flag
    reset_cycle("R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", q.size());
    end
    finish_run();
  end
endmodule